// File: doc/BRIEF.md
# SD command sequencing master

This block runs one command exchange with an SD card, clocked on the card clock. A one-cycle start strobe captures a 32-bit argument, a 14-bit command word and a 16-bit timeout limit. From these the block forms the 40-bit command frame and tells a bit-level serializer below it what length of response to expect. It then raises a transfer request and holds it until the serializer reports completion or until the timeout runs out.

When the serializer reports completion, the block captures the 120-bit response into four 32-bit words. It checks the CRC and index flags, but only if the command word enables those checks. If the busy check is enabled, it waits until the card releases its busy signal. It then sets sticky status bits. If the timeout runs out, it drops the request, flags the error and pulses a go-idle request so that the serializer returns to idle. Software clears the status with a pulse, and the status also clears by itself when a new command is accepted.

Top module: `sd_cmd_seq`

## Requirements
- R1: The frame is, from MSB down, a 0 bit, a 1 bit, the 6-bit index taken from command word bits [13:8], and then the 32-bit argument. For example, index 1 with argument 0x01234567 gives 0x4101234567.
- R2: The response-length output equals command word bits [1:0]: 00 means no response, 01 means short, 11 means long. It is 00 while reset is held.
- R3: The transfer request goes high in the cycle after an accepted start and falls in the cycle after done_in is seen. Status bit 0 (complete) is set on that same edge when no busy wait applies.
- R4: If command word bit 3 is set and crc_good is low at done, the status reads 5'b01011. If bit 3 is clear, crc_good has no effect.
- R5: If command word bit 4 is set and idx_good is low at done, the status reads 5'b10011. If the CRC check also fails, the status reads 5'b11011.
- R6: At done, response word 0 takes rsp_in[119:88], word 1 takes [87:56], word 2 takes [55:24], and word 3 takes {rsp_in[23:0], 8'h00}.
- R7: The status clears on a stat_clr pulse and on an accepted start. If a status-setting event falls in the same cycle as stat_clr, the event wins.
- R8: Let T be the latched timeout. The request cycles are counted from 0. If done_in is not seen by the cycle numbered T, the request falls and the status reads 5'b00110. go_idle is high for exactly one cycle. A done_in seen in cycle T counts as success.
- R9: If command word bit 2 is set, completion waits after done_in while busy_in is high. The status is written on the edge after busy_in is first seen low.
- R10: While reset is held, the response-length output, go_idle, the transfer request and the status are all zero.
- R11: A start that arrives while a transaction is in progress is ignored. The frame and response length keep the values latched by the accepted start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Card-domain clock |
| rst | input | 1 | Asynchronous reset, active high |
| start | input | 1 | One-cycle command start strobe |
| stat_clr | input | 1 | Status clear pulse |
| arg_in | input | 32 | Command argument, sampled on accepted start |
| cmd_in | input | 14 | Command word: index [13:8], index check [4], CRC check [3], busy check [2], response type [1:0] |
| tmo_in | input | 16 | Timeout limit in cycles |
| rsp_len | output | 2 | Response length for the serializer |
| xfr_req | output | 1 | Transfer request to the serializer |
| go_idle | output | 1 | One-cycle request to reset the serializer after a timeout |
| frame | output | 40 | Command frame |
| rsp_in | input | 120 | Received response bits |
| crc_good | input | 1 | Response CRC matched (valid with done_in) |
| idx_good | input | 1 | Response index matched (valid with done_in) |
| done_in | input | 1 | Serializer finished |
| busy_in | input | 1 | Card signals busy |
| status | output | 5 | Sticky status: idx err, crc err, timeout, any error, complete |
| rsp_w0 | output | 32 | Response word 0 |
| rsp_w1 | output | 32 | Response word 1 |
| rsp_w2 | output | 32 | Response word 2 |
| rsp_w3 | output | 32 | Response word 3 |

## Verification
Two pairs of events can land on the same edge. The first pair is completion and a status clear. The bench raises stat_clr together with done_in and expects to read the full completion status, not zero. The second pair is done_in and the timeout expiry. The bench delivers done_in exactly in request cycle T and expects a success status with no go-idle pulse. In both cases a scoreboard queue holds the expected status and response words, and the monitor compares them at the first status change.

// File: rtl/sd_cmd_seq_pkg.sv
package sd_cmd_seq_pkg;
   localparam int IDX_W  = 6;
   localparam int STAT_W = 5;

   typedef enum logic [1:0] {
      S_IDLE = 2'd0,
      S_XFER = 2'd1,
      S_BUSY = 2'd2
   } seq_state_e;

   typedef struct packed {
      logic [IDX_W-1:0] index;
      logic             idx_chk;
      logic             crc_chk;
      logic             busy_chk;
      logic [1:0]       rtype;
   } cmd_fields_t;

   // status layout: {idx err, crc err, timeout, any err, complete}
   function automatic logic [STAT_W-1:0] pack_status(input logic done,
                                                     input logic tmo,
                                                     input logic crc_bad,
                                                     input logic idx_bad);
      return {idx_bad, crc_bad, tmo, (tmo | crc_bad | idx_bad), done};
   endfunction
endpackage

// File: rtl/sd_cmd_seq_dec.sv
module sd_cmd_seq_dec
   import sd_cmd_seq_pkg::*;
#(
   parameter int ARG_W   = 32,
   parameter int CMD_W   = 14,
   parameter int FRAME_W = 40
) (
   input  logic [CMD_W-1:0]   cmd,
   input  logic [ARG_W-1:0]   arg,
   output cmd_fields_t        fld,
   output logic [FRAME_W-1:0] frame
);
   if (CMD_W != 14) begin : g_bad_cmd
      $error("sd_cmd_seq_dec: CMD_W must be 14");
   end
   if (FRAME_W != ARG_W + 2 + IDX_W) begin : g_bad_frame
      $error("sd_cmd_seq_dec: FRAME_W mismatch");
   end

   logic unused_mid;
   assign unused_mid = ^cmd[7:5];

   always_comb begin
      fld.index    = cmd[13:8];
      fld.idx_chk  = cmd[4];
      fld.crc_chk  = cmd[3];
      fld.busy_chk = cmd[2];
      fld.rtype    = cmd[1:0];
   end

   assign frame = {1'b0, 1'b1, fld.index, arg};
endmodule

// File: rtl/sd_cmd_seq_tmr.sv
module sd_cmd_seq_tmr #(
   parameter int TMO_W = 16
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             clr,
   input  logic             run,
   input  logic [TMO_W-1:0] limit,
   output logic             expired
);
   if (TMO_W < 1) begin : g_bad_w
      $error("sd_cmd_seq_tmr: TMO_W must be positive");
   end

   logic [TMO_W-1:0] cnt;

   always_ff @(posedge clk or posedge rst) begin
      if (rst)
         cnt <= '0;
      else if (clr)
         cnt <= '0;
      else if (run && (cnt != limit))
         cnt <= cnt + 1'b1;
   end

   assign expired = run && (cnt == limit);
endmodule

// File: rtl/sd_cmd_seq_rsp.sv
module sd_cmd_seq_rsp #(
   parameter int RSP_W  = 120,
   parameter int WORD_W = 32,
   parameter int NWORDS = 4
) (
   input  logic                     clk,
   input  logic                     rst,
   input  logic                     load,
   input  logic [RSP_W-1:0]         rsp_in,
   output logic [NWORDS*WORD_W-1:0] words
);
   localparam int TOT_W = NWORDS * WORD_W;
   localparam int PAD_W = TOT_W - RSP_W;

   if (RSP_W > TOT_W) begin : g_bad_fit
      $error("sd_cmd_seq_rsp: response wider than word store");
   end

   logic [TOT_W-1:0] aligned;

   if (PAD_W > 0) begin : g_pad
      assign aligned = {rsp_in, {PAD_W{1'b0}}};
   end else begin : g_nopad
      assign aligned = rsp_in;
   end

   for (genvar i = 0; i < NWORDS; i++) begin : g_word
      always_ff @(posedge clk or posedge rst) begin
         if (rst)
            words[TOT_W-1-i*WORD_W -: WORD_W] <= '0;
         else if (load)
            words[TOT_W-1-i*WORD_W -: WORD_W] <= aligned[TOT_W-1-i*WORD_W -: WORD_W];
      end
   end
endmodule

// File: rtl/sd_cmd_seq.sv
module sd_cmd_seq
   import sd_cmd_seq_pkg::*;
#(
   parameter int ARG_W  = 32,
   parameter int CMD_W  = 14,
   parameter int TMO_W  = 16,
   parameter int RSP_W  = 120,
   parameter int WORD_W = 32
) (
   input  logic                      clk,
   input  logic                      rst,
   input  logic                      start,
   input  logic                      stat_clr,
   input  logic [ARG_W-1:0]          arg_in,
   input  logic [CMD_W-1:0]          cmd_in,
   input  logic [TMO_W-1:0]          tmo_in,
   output logic [1:0]                rsp_len,
   output logic                      xfr_req,
   output logic                      go_idle,
   output logic [ARG_W+2+IDX_W-1:0]  frame,
   input  logic [RSP_W-1:0]          rsp_in,
   input  logic                      crc_good,
   input  logic                      idx_good,
   input  logic                      done_in,
   input  logic                      busy_in,
   output logic [STAT_W-1:0]         status,
   output logic [WORD_W-1:0]         rsp_w0,
   output logic [WORD_W-1:0]         rsp_w1,
   output logic [WORD_W-1:0]         rsp_w2,
   output logic [WORD_W-1:0]         rsp_w3
);
   localparam int FRAME_W = ARG_W + 2 + IDX_W;
   localparam int NWORDS  = 4;

   if (RSP_W > NWORDS * WORD_W) begin : g_bad_rsp
      $error("sd_cmd_seq: RSP_W exceeds four words");
   end

   seq_state_e         st;
   logic [ARG_W-1:0]   arg_q;
   logic [CMD_W-1:0]   cmd_q;
   logic [TMO_W-1:0]   tmo_q;
   logic               crc_bad_q;
   logic               idx_bad_q;
   cmd_fields_t        fld;
   logic               accept;
   logic               expired;
   logic               rsp_load;
   logic               crc_bad_now;
   logic               idx_bad_now;
   logic [NWORDS*WORD_W-1:0] words;

   assign accept      = (st == S_IDLE) && start;
   assign rsp_load    = (st == S_XFER) && done_in;
   assign crc_bad_now = fld.crc_chk && !crc_good;
   assign idx_bad_now = fld.idx_chk && !idx_good;

   sd_cmd_seq_dec #(
      .ARG_W  (ARG_W),
      .CMD_W  (CMD_W),
      .FRAME_W(FRAME_W)
   ) u_dec (
      .cmd  (cmd_q),
      .arg  (arg_q),
      .fld  (fld),
      .frame(frame)
   );

   sd_cmd_seq_tmr #(
      .TMO_W(TMO_W)
   ) u_tmr (
      .clk    (clk),
      .rst    (rst),
      .clr    (accept),
      .run    (st == S_XFER),
      .limit  (tmo_q),
      .expired(expired)
   );

   sd_cmd_seq_rsp #(
      .RSP_W (RSP_W),
      .WORD_W(WORD_W),
      .NWORDS(NWORDS)
   ) u_rsp (
      .clk   (clk),
      .rst   (rst),
      .load  (rsp_load),
      .rsp_in(rsp_in),
      .words (words)
   );

   always_ff @(posedge clk or posedge rst) begin
      if (rst) begin
         st        <= S_IDLE;
         arg_q     <= '0;
         cmd_q     <= '0;
         tmo_q     <= '0;
         crc_bad_q <= 1'b0;
         idx_bad_q <= 1'b0;
         xfr_req   <= 1'b0;
         go_idle   <= 1'b0;
         status    <= '0;
      end else begin
         go_idle <= 1'b0;
         if (stat_clr)
            status <= '0;
         unique case (st)
            S_IDLE: begin
               if (start) begin
                  arg_q   <= arg_in;
                  cmd_q   <= cmd_in;
                  tmo_q   <= tmo_in;
                  status  <= '0;
                  xfr_req <= 1'b1;
                  st      <= S_XFER;
               end
            end
            S_XFER: begin
               if (done_in) begin
                  xfr_req <= 1'b0;
                  if (fld.busy_chk) begin
                     crc_bad_q <= crc_bad_now;
                     idx_bad_q <= idx_bad_now;
                     st        <= S_BUSY;
                  end else begin
                     status <= pack_status(1'b1, 1'b0, crc_bad_now, idx_bad_now);
                     st     <= S_IDLE;
                  end
               end else if (expired) begin
                  xfr_req <= 1'b0;
                  go_idle <= 1'b1;
                  status  <= pack_status(1'b0, 1'b1, 1'b0, 1'b0);
                  st      <= S_IDLE;
               end
            end
            S_BUSY: begin
               if (!busy_in) begin
                  status <= pack_status(1'b1, 1'b0, crc_bad_q, idx_bad_q);
                  st     <= S_IDLE;
               end
            end
            default: st <= S_IDLE;
         endcase
      end
   end

   assign rsp_len = fld.rtype;
   assign rsp_w0  = words[4*WORD_W-1 -: WORD_W];
   assign rsp_w1  = words[3*WORD_W-1 -: WORD_W];
   assign rsp_w2  = words[2*WORD_W-1 -: WORD_W];
   assign rsp_w3  = words[WORD_W-1 -: WORD_W];
endmodule

// File: rtl/sd_cmd_seq_chk.sv
module sd_cmd_seq_chk #(
   parameter int FRAME_W = 40
) (
   input logic               clk,
   input logic               rst,
   input logic               done_in,
   input logic               xfr_req,
   input logic               go_idle,
   input logic [4:0]         status,
   input logic [FRAME_W-1:0] frame,
   input logic [1:0]         rsp_len
);
   assert_req_drop_R3: assert property (@(posedge clk) disable iff (rst)
      (xfr_req && done_in) |=> !xfr_req);

   assert_done_after_req_R3: assert property (@(posedge clk) disable iff (rst)
      $rose(status[0]) |-> !xfr_req);

   assert_err_summary_R4: assert property (@(posedge clk) disable iff (rst)
      (status[4] || status[3] || status[2]) |-> status[1]);

   assert_idle_pulse_R8: assert property (@(posedge clk) disable iff (rst)
      go_idle |=> !go_idle);

   assert_idle_status_R8: assert property (@(posedge clk) disable iff (rst)
      go_idle |-> (status == 5'b00110) && !xfr_req);

   assert_hold_cmd_R11: assert property (@(posedge clk) disable iff (rst)
      xfr_req |=> ($stable(frame) && $stable(rsp_len)));
endmodule

bind sd_cmd_seq sd_cmd_seq_chk #(.FRAME_W(ARG_W + 2 + 6)) u_chk (
   .clk    (clk),
   .rst    (rst),
   .done_in(done_in),
   .xfr_req(xfr_req),
   .go_idle(go_idle),
   .status (status),
   .frame  (frame),
   .rsp_len(rsp_len)
);

// File: tb/tb_sd_cmd_seq.sv
module tb_sd_cmd_seq;
   logic         clk = 1'b0;
   logic         rst = 1'b1;
   logic         start = 1'b0;
   logic         stat_clr = 1'b0;
   logic [31:0]  arg_in = '0;
   logic [13:0]  cmd_in = '0;
   logic [15:0]  tmo_in = '0;
   logic [1:0]   rsp_len;
   logic         xfr_req;
   logic         go_idle;
   logic [39:0]  frame;
   logic [119:0] rsp_in = '0;
   logic         crc_good = 1'b0;
   logic         idx_good = 1'b0;
   logic         done_in = 1'b0;
   logic         busy_in = 1'b0;
   logic [4:0]   status;
   logic [31:0]  rsp_w0, rsp_w1, rsp_w2, rsp_w3;

   int checks = 0;
   int fails  = 0;
   bit ended  = 0;

   logic [4:0]   exp_st_q[$];
   logic [127:0] exp_w_q[$];
   string        exp_tag_q[$];
   logic [127:0] last_words = '0;

   always #2 clk = ~clk;

   sd_cmd_seq dut (
      .clk(clk), .rst(rst), .start(start), .stat_clr(stat_clr),
      .arg_in(arg_in), .cmd_in(cmd_in), .tmo_in(tmo_in),
      .rsp_len(rsp_len), .xfr_req(xfr_req), .go_idle(go_idle),
      .frame(frame), .rsp_in(rsp_in), .crc_good(crc_good),
      .idx_good(idx_good), .done_in(done_in), .busy_in(busy_in),
      .status(status), .rsp_w0(rsp_w0), .rsp_w1(rsp_w1),
      .rsp_w2(rsp_w2), .rsp_w3(rsp_w3)
   );

   task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic finish_run();
      if (!ended) begin
         ended = 1;
         $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
         $finish;
      end
   endtask

   // monitor: compares on each 0 -> nonzero status transition
   logic [4:0] prev_st = '0;
   always @(negedge clk) begin
      if (!rst) begin
         if (prev_st == 5'd0 && status != 5'd0) begin
            if (exp_st_q.size() == 0) begin
               checks++;
               fails++;
               $display("FAIL R3 unexpected status actual=%0h expected=none", status);
            end else begin
               string tg;
               tg = exp_tag_q.pop_front();
               chk({tg, " status"}, {123'd0, status}, {123'd0, exp_st_q.pop_front()});
               chk({"R6 ", tg, " words"}, {rsp_w0, rsp_w1, rsp_w2, rsp_w3}, exp_w_q.pop_front());
            end
         end
         prev_st <= status;
      end
   end

   // driver: one transaction, expected result pushed to the scoreboard
   task automatic xact(input string tag, input logic [5:0] idx, input logic [1:0] rt,
                       input bit ben, input bit cen, input bit ien,
                       input logic [31:0] a, input logic [15:0] t, input int wait_n,
                       input bit cg, input bit ig, input int busy_n,
                       input logic [119:0] r, input bit clr_at_done, input bit poke);
      int elapsed;
      bit timeout;
      logic [4:0] es;
      timeout = (wait_n > int'(t));
      @(negedge clk);
      start  = 1'b1;
      arg_in = a;
      cmd_in = {idx, 3'b000, ien, cen, ben, rt};
      tmo_in = t;
      @(negedge clk);
      start = 1'b0; arg_in = '0; cmd_in = '0; tmo_in = '0;
      chk({"R3 ", tag, " req rise"}, {127'd0, xfr_req}, 128'd1);
      chk({"R1 ", tag, " frame"}, {88'd0, frame}, {88'd0, 2'b01, idx, a});
      chk({"R2 ", tag, " rsp_len"}, {126'd0, rsp_len}, {126'd0, rt});
      chk({"R7 ", tag, " start clears"}, {123'd0, status}, 128'd0);
      elapsed = 0;
      if (poke) begin
         start = 1'b1; arg_in = 32'hffff_ffff; cmd_in = '1; tmo_in = '1;
         @(negedge clk);
         start = 1'b0; arg_in = '0; cmd_in = '0; tmo_in = '0;
         elapsed = 1;
         chk({"R11 ", tag, " frame kept"}, {88'd0, frame}, {88'd0, 2'b01, idx, a});
         chk({"R11 ", tag, " rsp_len kept"}, {126'd0, rsp_len}, {126'd0, rt});
         chk({"R11 ", tag, " req kept"}, {127'd0, xfr_req}, 128'd1);
      end
      if (timeout) begin
         for (int k = elapsed; k < int'(t); k++) @(negedge clk);
         chk({"R8 ", tag, " req at limit"}, {127'd0, xfr_req}, 128'd1);
         exp_st_q.push_back(5'b00110);
         exp_w_q.push_back(last_words);
         exp_tag_q.push_back({"R8 ", tag});
         @(negedge clk);
         chk({"R8 ", tag, " req dropped"}, {127'd0, xfr_req}, 128'd0);
         chk({"R8 ", tag, " go_idle high"}, {127'd0, go_idle}, 128'd1);
         @(negedge clk);
         chk({"R8 ", tag, " go_idle one cycle"}, {127'd0, go_idle}, 128'd0);
      end else begin
         for (int k = elapsed; k < wait_n; k++) @(negedge clk);
         es = {ien & !ig, cen & !cg, 1'b0, (ien & !ig) | (cen & !cg), 1'b1};
         last_words = {r, 8'h00};
         exp_st_q.push_back(es);
         exp_w_q.push_back(last_words);
         exp_tag_q.push_back({"R3 ", tag});
         done_in = 1'b1; rsp_in = r; crc_good = cg; idx_good = ig;
         busy_in = (busy_n > 0); stat_clr = clr_at_done;
         @(negedge clk);
         done_in = 1'b0; rsp_in = '0; crc_good = 1'b0; idx_good = 1'b0; stat_clr = 1'b0;
         chk({"R3 ", tag, " req fall"}, {127'd0, xfr_req}, 128'd0);
         chk({"R8 ", tag, " no go_idle"}, {127'd0, go_idle}, 128'd0);
         if (busy_n > 0) begin
            chk({"R9 ", tag, " held by busy"}, {123'd0, status}, 128'd0);
            for (int k = 1; k < busy_n; k++) begin
               @(negedge clk);
               chk({"R9 ", tag, " still held"}, {123'd0, status}, 128'd0);
            end
            busy_in = 1'b0;
            @(negedge clk);
            chk({"R9 ", tag, " after busy"}, {123'd0, status}, {123'd0, es});
         end
      end
      @(negedge clk);
   endtask

   initial begin
      repeat (30000) @(posedge clk);
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=running expected=done");
      finish_run();
   end

   initial begin
      repeat (3) @(negedge clk);
      chk("R10 status in reset", {123'd0, status}, 128'd0);
      chk("R10 go_idle in reset", {127'd0, go_idle}, 128'd0);
      chk("R10 rsp_len in reset", {126'd0, rsp_len}, 128'd0);
      chk("R10 req in reset", {127'd0, xfr_req}, 128'd0);
      rst = 1'b0;
      repeat (2) @(negedge clk);

      xact("no-rsp", 6'd1, 2'b00, 0, 0, 0, 32'h01234567, 16'd100, 10, 0, 0, 0, '0, 0, 0);
      chk("R1 literal frame", {88'd0, frame}, {88'd0, 40'h4101234567});
      stat_clr = 1'b1;
      @(negedge clk);
      stat_clr = 1'b0;
      chk("R7 clear pulse", {123'd0, status}, 128'd0);

      xact("short", 6'd5, 2'b01, 0, 0, 0, 32'hdeadbeef, 16'd100, 10, 0, 0, 0,
           120'h0102030405060708090a0b0c0d0e0f, 0, 0);
      chk("R6 word3 padded", {96'd0, rsp_w3}, {96'd0, 32'h0d0e0f00});
      xact("long", 6'h15, 2'b11, 0, 0, 0, 32'hbad0dad0, 16'd100, 10, 0, 0, 0,
           120'h1112131415161718191a1b1c1d1e1f, 0, 0);
      chk("R6 word0", {96'd0, rsp_w0}, {96'd0, 32'h11121314});

      xact("R4 crc ok", 6'd5, 2'b01, 0, 1, 0, 32'h0, 16'd100, 4, 1, 0, 0, '0, 0, 0);
      xact("R4 crc bad", 6'd5, 2'b01, 0, 1, 0, 32'h0, 16'd100, 4, 0, 0, 0, '0, 0, 0);
      xact("R4 crc ignored", 6'd5, 2'b01, 0, 0, 0, 32'h0, 16'd100, 4, 0, 1, 0, '0, 0, 0);
      xact("R5 idx ok", 6'd5, 2'b01, 0, 0, 1, 32'h0, 16'd100, 4, 0, 1, 0, '0, 0, 0);
      xact("R5 idx bad", 6'd5, 2'b01, 0, 0, 1, 32'h0, 16'd100, 4, 1, 0, 0, '0, 0, 0);
      xact("R5 both bad", 6'd5, 2'b01, 0, 1, 1, 32'h0, 16'd100, 4, 0, 0, 0, '0, 0, 0);

      xact("R8 timeout", 6'd5, 2'b01, 0, 1, 1, 32'h0, 16'd10, 999, 0, 0, 0, '0, 0, 0);
      xact("R8 after timeout", 6'd5, 2'b01, 0, 0, 0, 32'hdeadbeef, 16'd100, 10, 0, 0, 0,
           120'h0102030405060708090a0b0c0d0e0f, 0, 0);
      xact("R8 done on expiry", 6'd7, 2'b01, 0, 0, 0, 32'h5a5a5a5a, 16'd6, 6, 0, 0, 0,
           120'hcafe, 0, 0);
      xact("R8 zero limit", 6'd2, 2'b00, 0, 0, 0, 32'h1, 16'd0, 0, 0, 0, 0, 120'h77, 0, 0);

      xact("R9 busy", 6'h35, 2'b01, 1, 1, 0, 32'h0, 16'd100, 10, 1, 0, 5, 120'hbeef, 0, 0);
      xact("R9 busy bad crc", 6'h35, 2'b01, 1, 1, 0, 32'h0, 16'd100, 3, 0, 0, 2, 120'h1, 0, 0);

      xact("R7 clear vs done", 6'd9, 2'b01, 0, 1, 0, 32'h0, 16'd100, 5, 0, 0, 0, 120'h2, 1, 0);
      xact("R11 ignored start", 6'd12, 2'b11, 0, 0, 0, 32'h13572468, 16'd100, 6, 0, 0, 0,
           120'h3, 0, 1);

      repeat (3) @(negedge clk);
      chk("R3 scoreboard drained", {96'd0, 32'(exp_st_q.size())}, 128'd0);
      finish_run();
   end
endmodule